// File: doc/BRIEF.md
# Interruptible DDR Write Burst Capture

This block sits on the memory side of a double-data-rate interface and turns Write commands into per-beat array writes. Each command names a bank and a starting column. One clock later the data arrives as a rising-edge and falling-edge beat pair per clock, each beat carrying its own mask bit. The block works out the column of every beat and presents registered write enables, addresses and data. It also stores the unmasked beats in a small internal array, which a registered read port exposes.

A new Write may arrive on any rising edge, including while an earlier burst is still taking data. The beat pair sampled on that same edge still belongs to the older burst, because the new command's one-clock latency has not yet passed. From the next edge on, the beats belong to the new burst, which runs its full length from its own address. Any columns the older burst had not yet reached are abandoned. Cutting short a burst that was opened with auto-precharge is not allowed. The block raises a one-cycle flag when that happens, but still honours the new command.

Top module: `ddr_wburst_capture`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, both write enables and the illegal flag are low, and no burst is running.
- R2: Write latency is one clock. For a command sampled at edge k, beat pairs are sampled at edges k+1 and k+2. The matching write outputs are registered and visible after edges k+1 and k+2.
- R3: The burst length is 4. Beat i of a burst goes to the command's bank, at column {col[3:2], (col[1:0]+i) mod 4}. The rising beat of pair p is beat 2p and the falling beat is beat 2p+1.
- R4: A beat whose mask bit is 1 has its write enable low and leaves the array unchanged. A beat whose mask bit is 0 is written.
- R5: A Write sampled while the running burst still has a pair after the current edge drops that burst's remaining beats. A full 4-beat burst starts from the new bank and column.
- R6: The beat pair sampled on the edge that carries an interrupting Write is written to the older burst's addresses.
- R7: A Write may be sampled on every rising edge. Each one starts its own burst.
- R8: Command codes are 00 NOP, 01 WRITE, 10 WRITE with auto-precharge, and 11 reserved. The illegal flag is high for one cycle after an edge at which a Write (01 or 10) cuts short a burst that was opened with code 10. It stays low when the burst cut short was opened with code 01, and when the code-10 burst had already finished.
- R9: A Write that raises the illegal flag still takes effect as in R5.
- R10: The read port returns the array byte at the given bank and column one clock after the address is sampled.
- R11: Beat data sampled while no burst is running is ignored. The reserved code 11 acts as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code (00 NOP, 01 WRITE, 10 WRITE with auto-precharge, 11 reserved) |
| bank_i | input | 2 | Bank of a Write |
| col_i | input | 4 | Starting column of a Write |
| dq_rise_i | input | 8 | Rising-edge beat data |
| dq_fall_i | input | 8 | Falling-edge beat data |
| dm_rise_i | input | 1 | Mask for rising-edge beat (1 = skip) |
| dm_fall_i | input | 1 | Mask for falling-edge beat (1 = skip) |
| rd_bank_i | input | 2 | Read port bank |
| rd_col_i | input | 4 | Read port column |
| wr_en_rise_o | output | 1 | Rising beat write enable |
| wr_en_fall_o | output | 1 | Falling beat write enable |
| wr_bank_o | output | 2 | Bank of the current beat pair |
| wr_col_rise_o | output | 4 | Column of the rising beat |
| wr_col_fall_o | output | 4 | Column of the falling beat |
| wr_data_rise_o | output | 8 | Rising beat data |
| wr_data_fall_o | output | 8 | Falling beat data |
| illegal_o | output | 1 | One-cycle flag for an auto-precharge burst cut short |
| rd_data_o | output | 8 | Read port data |

## Verification
The assertions take for granted that the command and mask inputs are known at every sampling edge. They also assume reset is held for at least one clock before the first command. The bench drives only defined values, holds reset for several cycles, and changes inputs only on the falling clock edge. Its random phase mixes all four command codes, so interruptions, auto-precharge violations and back-to-back Writes arise within those limits alongside the directed cases.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_WR  = 2'b01,
    CMD_WRA = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  function automatic logic is_write(input logic [1:0] code);
    return (code == CMD_WR) || (code == CMD_WRA);
  endfunction
endpackage

// File: rtl/ddrw_burst_seq.sv
module ddrw_burst_seq #(
  parameter int BW    = 2,
  parameter int CW    = 4,
  parameter int PAIRS = 2,
  localparam int PW   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] col_i,
  output logic          busy_o,
  output logic [BW-1:0] bank_o,
  output logic [CW-1:0] col_o,
  output logic [PW-1:0] pair_o,
  output logic          illegal_o
);
  import ddrw_pkg::*;

  logic          busy_q, autop_q, illegal_q;
  logic [BW-1:0] bank_q;
  logic [CW-1:0] col_q;
  logic [PW-1:0] pair_q;
  logic          wr_hit, last_pair, cut_short;

  assign wr_hit    = is_write(cmd_i);
  assign last_pair = (pair_q == PW'(PAIRS - 1));
  assign cut_short = busy_q && !last_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      autop_q   <= 1'b0;
      illegal_q <= 1'b0;
      bank_q    <= '0;
      col_q     <= '0;
      pair_q    <= '0;
    end else begin
      illegal_q <= wr_hit && cut_short && autop_q;
      if (wr_hit) begin
        busy_q  <= 1'b1;
        autop_q <= (cmd_i == CMD_WRA);
        bank_q  <= bank_i;
        col_q   <= col_i;
        pair_q  <= '0;
      end else if (busy_q) begin
        if (last_pair) begin
          busy_q <= 1'b0;
          pair_q <= '0;
        end else begin
          pair_q <= pair_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign bank_o    = bank_q;
  assign col_o     = col_q;
  assign pair_o    = pair_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/ddrw_beat_map.sv
module ddrw_beat_map #(
  parameter int BW  = 2,
  parameter int CW  = 4,
  parameter int DW  = 8,
  parameter int BL  = 4,
  localparam int PAIRS = BL / 2,
  localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int LBW   = $clog2(BL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] col_i,
  input  logic [PW-1:0] pair_i,
  input  logic [DW-1:0] dq_rise_i,
  input  logic [DW-1:0] dq_fall_i,
  input  logic          dm_rise_i,
  input  logic          dm_fall_i,
  output logic          en_rise_o,
  output logic          en_fall_o,
  output logic [BW-1:0] bank_o,
  output logic [CW-1:0] col_rise_o,
  output logic [CW-1:0] col_fall_o,
  output logic [DW-1:0] data_rise_o,
  output logic [DW-1:0] data_fall_o
);
  logic [LBW-1:0] base, off_rise, off_fall;
  logic [CW-1:0]  col_rise_d, col_fall_d;

  always_comb begin
    base       = col_i[LBW-1:0];
    off_rise   = base + LBW'({pair_i, 1'b0});
    off_fall   = base + LBW'({pair_i, 1'b1});
    col_rise_d = {col_i[CW-1:LBW], off_rise};
    col_fall_d = {col_i[CW-1:LBW], off_fall};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_rise_o   <= 1'b0;
      en_fall_o   <= 1'b0;
      bank_o      <= '0;
      col_rise_o  <= '0;
      col_fall_o  <= '0;
      data_rise_o <= '0;
      data_fall_o <= '0;
    end else begin
      en_rise_o   <= busy_i && !dm_rise_i;
      en_fall_o   <= busy_i && !dm_fall_i;
      bank_o      <= bank_i;
      col_rise_o  <= col_rise_d;
      col_fall_o  <= col_fall_d;
      data_rise_o <= dq_rise_i;
      data_fall_o <= dq_fall_i;
    end
  end
endmodule

// File: rtl/ddrw_store.sv
module ddrw_store #(
  parameter int BANKS = 4,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  localparam int BW    = $clog2(BANKS),
  localparam int CW    = $clog2(COLS),
  localparam int AW    = BW + CW - 1,
  localparam int DEPTH = BANKS * COLS / 2
) (
  input  logic          clk,
  input  logic          en_rise_i,
  input  logic          en_fall_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] col_rise_i,
  input  logic [CW-1:0] col_fall_i,
  input  logic [DW-1:0] data_rise_i,
  input  logic [DW-1:0] data_fall_i,
  input  logic [BW-1:0] rd_bank_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [DW-1:0] rd_data_o
);
  logic rd_sel_q;

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_par
      logic          we;
      logic [AW-1:0] waddr, raddr;
      logic [DW-1:0] wdat, rq;
      logic [DW-1:0] mem [DEPTH];
      logic          rise_here;

      assign rise_here = (col_rise_i[0] == 1'(p));
      assign we    = rise_here ? en_rise_i : en_fall_i;
      assign waddr = rise_here ? {bank_i, col_rise_i[CW-1:1]}
                               : {bank_i, col_fall_i[CW-1:1]};
      assign wdat  = rise_here ? data_rise_i : data_fall_i;
      assign raddr = {rd_bank_i, rd_col_i[CW-1:1]};

      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdat;
        rq <= mem[raddr];
      end
    end
  endgenerate

  always_ff @(posedge clk) rd_sel_q <= rd_col_i[0];

  assign rd_data_o = rd_sel_q ? g_par[1].rq : g_par[0].rq;
endmodule

// File: rtl/ddr_wburst_capture.sv
module ddr_wburst_capture #(
  parameter int BANKS = 4,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int BL    = 4,
  localparam int BW    = $clog2(BANKS),
  localparam int CW    = $clog2(COLS),
  localparam int PAIRS = BL / 2,
  localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic [CW-1:0] col_i,
  input  logic [DW-1:0] dq_rise_i,
  input  logic [DW-1:0] dq_fall_i,
  input  logic          dm_rise_i,
  input  logic          dm_fall_i,
  input  logic [BW-1:0] rd_bank_i,
  input  logic [CW-1:0] rd_col_i,
  output logic          wr_en_rise_o,
  output logic          wr_en_fall_o,
  output logic [BW-1:0] wr_bank_o,
  output logic [CW-1:0] wr_col_rise_o,
  output logic [CW-1:0] wr_col_fall_o,
  output logic [DW-1:0] wr_data_rise_o,
  output logic [DW-1:0] wr_data_fall_o,
  output logic          illegal_o,
  output logic [DW-1:0] rd_data_o
);
  logic          seq_busy;
  logic [BW-1:0] seq_bank;
  logic [CW-1:0] seq_col;
  logic [PW-1:0] seq_pair;

  ddrw_burst_seq #(.BW(BW), .CW(CW), .PAIRS(PAIRS)) u_seq (
    .clk       (clk_i),
    .rst       (rst_i),
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .col_i     (col_i),
    .busy_o    (seq_busy),
    .bank_o    (seq_bank),
    .col_o     (seq_col),
    .pair_o    (seq_pair),
    .illegal_o (illegal_o)
  );

  ddrw_beat_map #(.BW(BW), .CW(CW), .DW(DW), .BL(BL)) u_map (
    .clk         (clk_i),
    .rst         (rst_i),
    .busy_i      (seq_busy),
    .bank_i      (seq_bank),
    .col_i       (seq_col),
    .pair_i      (seq_pair),
    .dq_rise_i   (dq_rise_i),
    .dq_fall_i   (dq_fall_i),
    .dm_rise_i   (dm_rise_i),
    .dm_fall_i   (dm_fall_i),
    .en_rise_o   (wr_en_rise_o),
    .en_fall_o   (wr_en_fall_o),
    .bank_o      (wr_bank_o),
    .col_rise_o  (wr_col_rise_o),
    .col_fall_o  (wr_col_fall_o),
    .data_rise_o (wr_data_rise_o),
    .data_fall_o (wr_data_fall_o)
  );

  ddrw_store #(.BANKS(BANKS), .COLS(COLS), .DW(DW)) u_store (
    .clk         (clk_i),
    .en_rise_i   (wr_en_rise_o),
    .en_fall_i   (wr_en_fall_o),
    .bank_i      (wr_bank_o),
    .col_rise_i  (wr_col_rise_o),
    .col_fall_i  (wr_col_fall_o),
    .data_rise_i (wr_data_rise_o),
    .data_fall_i (wr_data_fall_o),
    .rd_bank_i   (rd_bank_i),
    .rd_col_i    (rd_col_i),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/ddrw_capture_chk.sv
module ddrw_capture_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cmd,
  input logic          dm_rise,
  input logic          dm_fall,
  input logic          busy,
  input logic          en_rise,
  input logic          en_fall,
  input logic [CW-1:0] col_rise,
  input logic [CW-1:0] col_fall,
  input logic          illegal
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!en_rise && !en_fall && !illegal));

  // R2, R11: a beat is only written if a burst was running at its sampling edge
  assert_beat_source_R2: assert property (@(posedge clk) disable iff (rst)
    (en_rise || en_fall) |-> $past(busy));

  assert_pair_columns_R3: assert property (@(posedge clk) disable iff (rst)
    (en_rise && en_fall) |->
      ((col_rise[0] != col_fall[0]) && (col_rise[CW-1:2] == col_fall[CW-1:2])));

  assert_mask_rise_R4: assert property (@(posedge clk) disable iff (rst)
    en_rise |-> !$past(dm_rise));

  assert_mask_fall_R4: assert property (@(posedge clk) disable iff (rst)
    en_fall |-> !$past(dm_fall));

  assert_illegal_cause_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($past(cmd) == 2'b01 || $past(cmd) == 2'b10));

  // R9: the violating Write still opens a burst
  assert_illegal_takes_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> busy);
endmodule

bind ddr_wburst_capture ddrw_capture_chk #(.CW(CW)) u_chk (
  .clk      (clk_i),
  .rst      (rst_i),
  .cmd      (cmd_i),
  .dm_rise  (dm_rise_i),
  .dm_fall  (dm_fall_i),
  .busy     (seq_busy),
  .en_rise  (wr_en_rise_o),
  .en_fall  (wr_en_fall_o),
  .col_rise (wr_col_rise_o),
  .col_fall (wr_col_fall_o),
  .illegal  (illegal_o)
);

// File: tb/sim_ddr_wburst_capture.sv
`timescale 1ns/1ps
module sim_ddr_wburst_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [1:0] bank = '0, rd_bank = '0, wr_bank;
  logic [3:0] col = '0, rd_col = '0, wr_col_r, wr_col_f;
  logic [7:0] dq_r = '0, dq_f = '0, wr_dat_r, wr_dat_f, rd_data;
  logic       dm_r = 1'b0, dm_f = 1'b0;
  logic       wr_en_r, wr_en_f, illegal;

  always #2.5 clk = ~clk;

  ddr_wburst_capture u0 (
    .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .bank_i(bank), .col_i(col),
    .dq_rise_i(dq_r), .dq_fall_i(dq_f), .dm_rise_i(dm_r), .dm_fall_i(dm_f),
    .rd_bank_i(rd_bank), .rd_col_i(rd_col),
    .wr_en_rise_o(wr_en_r), .wr_en_fall_o(wr_en_f), .wr_bank_o(wr_bank),
    .wr_col_rise_o(wr_col_r), .wr_col_fall_o(wr_col_f),
    .wr_data_rise_o(wr_dat_r), .wr_data_fall_o(wr_dat_f),
    .illegal_o(illegal), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [7:0] mm [4][16];
  bit m_busy = 0, m_autop = 0;
  int m_pair = 0, m_bank = 0, m_col = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int beat_col(input int c0, input int beat);
    return (c0 & 12) | ((c0 + beat) & 3);
  endfunction

  // one clock: entered and left at a falling edge
  task automatic step(input logic [1:0] c, input int b, input int cl,
                      input logic [7:0] dr, input logic [7:0] df,
                      input bit mr, input bit mf, input string tag);
    bit e_r, e_f, e_ill, is_wr;
    int e_cr, e_cf, e_b;
    cmd = c; bank = 2'(b); col = 4'(cl); dq_r = dr; dq_f = df; dm_r = mr; dm_f = mf;
    is_wr = (c == 2'b01) || (c == 2'b10);
    e_r = m_busy && !mr;
    e_f = m_busy && !mf;
    e_cr = beat_col(m_col, 2 * m_pair);
    e_cf = beat_col(m_col, 2 * m_pair + 1);
    e_b = m_bank;
    e_ill = is_wr && m_busy && (m_pair == 0) && m_autop;
    if (e_r) mm[e_b][e_cr] = dr;
    if (e_f) mm[e_b][e_cf] = df;
    if (is_wr) begin
      m_busy = 1; m_autop = (c == 2'b10); m_bank = b; m_col = cl; m_pair = 0;
    end else if (m_busy) begin
      if (m_pair == 1) m_busy = 0; else m_pair++;
    end
    @(posedge clk); #1;
    chk(wr_en_r == e_r, tag, "rise enable", int'(wr_en_r), int'(e_r));
    chk(wr_en_f == e_f, tag, "fall enable", int'(wr_en_f), int'(e_f));
    chk(illegal == e_ill, tag, "illegal flag", int'(illegal), int'(e_ill));
    if (e_r) begin
      chk(wr_col_r == 4'(e_cr), tag, "rise column", int'(wr_col_r), e_cr);
      chk(wr_dat_r == dr, tag, "rise data", int'(wr_dat_r), int'(dr));
    end
    if (e_f) begin
      chk(wr_col_f == 4'(e_cf), tag, "fall column", int'(wr_col_f), e_cf);
      chk(wr_dat_f == df, tag, "fall data", int'(wr_dat_f), int'(df));
    end
    if (e_r || e_f) chk(wr_bank == 2'(e_b), tag, "bank", int'(wr_bank), e_b);
    @(negedge clk);
  endtask

  task automatic nop(input string tag);
    step(2'b00, 0, 0, 8'hEE, 8'hDD, 0, 0, tag);
  endtask

  task automatic readback(input string tag);
    nop(tag); nop(tag);
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 16; c++) begin
        rd_bank = 2'(b); rd_col = 4'(c);
        @(posedge clk); #1;
        chk(rd_data == mm[b][c], tag, $sformatf("array b%0d c%0d", b, c),
            int'(rd_data), int'(mm[b][c]));
        @(negedge clk);
      end
    end
  endtask

  function automatic logic [1:0] pick_cmd(input int r);
    if (r < 60) return 2'b00;
    if (r < 85) return 2'b01;
    if (r < 95) return 2'b10;
    return 2'b11;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 4; b++) for (int c = 0; c < 16; c++) mm[b][c] = '0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet under reset
    chk(!wr_en_r && !wr_en_f && !illegal, "R1", "reset outputs",
        int'({wr_en_r, wr_en_f, illegal}), 0);
    rst = 1'b0;
    nop("R1");

    // fill every cell; data sent with the command itself must be ignored
    for (int b = 0; b < 4; b++) begin
      for (int g = 0; g < 4; g++) begin
        step(2'b01, b, g * 4, 8'hA5, 8'h5A, 0, 0, "R11");
        step(2'b00, 0, 0, 8'(b * 16 + g * 4), 8'(b * 16 + g * 4 + 1), 0, 0, "R2");
        step(2'b00, 0, 0, 8'(b * 16 + g * 4 + 2), 8'(b * 16 + g * 4 + 3), 0, 0, "R2");
      end
    end
    nop("R11");
    step(2'b11, 1, 3, 8'h11, 8'h22, 0, 0, "R11");
    nop("R11");

    // R3: wrapping start inside the group
    step(2'b01, 2, 6, 8'h00, 8'h00, 0, 0, "R3");
    step(2'b00, 0, 0, 8'hC6, 8'hC7, 0, 0, "R3");
    step(2'b00, 0, 0, 8'hC4, 8'hC5, 0, 0, "R3");
    step(2'b01, 3, 15, 8'h00, 8'h00, 0, 0, "R3");
    step(2'b00, 0, 0, 8'hF1, 8'hF2, 0, 0, "R3");
    step(2'b00, 0, 0, 8'hF3, 8'hF4, 0, 0, "R3");

    // R4: masked beats
    step(2'b01, 1, 8, 8'h00, 8'h00, 0, 0, "R4");
    step(2'b00, 0, 0, 8'h77, 8'h78, 1, 0, "R4");
    step(2'b00, 0, 0, 8'h79, 8'h7A, 0, 1, "R4");
    nop("R4");

    // R5/R6: plain interrupt, checked again through readback
    step(2'b01, 0, 0, 8'h00, 8'h00, 0, 0, "R5");
    step(2'b01, 2, 9, 8'hB0, 8'hB1, 0, 0, "R6");
    step(2'b00, 0, 0, 8'hB9, 8'hBA, 0, 0, "R5");
    step(2'b00, 0, 0, 8'hBB, 8'hB8, 0, 0, "R5");
    nop("R5");

    // R7: Write on consecutive edges
    step(2'b01, 0, 4, 8'h00, 8'h00, 0, 0, "R7");
    step(2'b01, 1, 5, 8'h41, 8'h42, 0, 0, "R7");
    step(2'b01, 3, 2, 8'h43, 8'h44, 0, 0, "R7");
    step(2'b00, 0, 0, 8'h45, 8'h46, 0, 0, "R7");
    step(2'b00, 0, 0, 8'h47, 8'h48, 0, 0, "R7");

    // R8/R9: auto-precharge cut short, then legal cases
    step(2'b10, 1, 0, 8'h00, 8'h00, 0, 0, "R8");
    step(2'b01, 1, 12, 8'h91, 8'h92, 0, 0, "R8");
    step(2'b00, 0, 0, 8'h93, 8'h94, 0, 0, "R9");
    step(2'b00, 0, 0, 8'h95, 8'h96, 0, 0, "R9");
    step(2'b10, 2, 0, 8'h00, 8'h00, 0, 0, "R8");
    step(2'b00, 0, 0, 8'h61, 8'h62, 0, 0, "R8");
    step(2'b10, 2, 4, 8'h63, 8'h64, 0, 0, "R8");
    step(2'b00, 0, 0, 8'h65, 8'h66, 0, 0, "R8");
    step(2'b10, 0, 8, 8'h67, 8'h68, 0, 0, "R8");
    step(2'b00, 0, 0, 8'h69, 8'h6A, 0, 0, "R8");
    step(2'b00, 0, 0, 8'h6B, 8'h6C, 0, 0, "R8");
    readback("R10");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      step(pick_cmd($urandom_range(99)), $urandom_range(3), $urandom_range(15),
           8'($urandom), 8'($urandom), ($urandom_range(7) == 0), ($urandom_range(7) == 0),
           "R5");
    end
    readback("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule